// File: doc/BRIEF.md
# Crossbar Interconnect with Per-Target Round-Robin Arbitration

This block joins a set of initiators to a set of targets through a full matrix of switch points, so every initiator can reach every target. Each initiator raises a request together with the index of the target it wants, its write data and a done flag on the last cycle of its transaction. Each target owns an independent arbiter, so initiators that ask for different targets are all connected in the same cycle, and up to min(initiators, targets) transfers run side by side.

A target that is wanted by several initiators at once picks one of them with a rotating turn pointer. The winner keeps the target until it ends its transaction. The turn pointer then moves to the initiator after the winner, so no requester waits longer than (initiators − 1) transactions. Any initiator that has not been granted sees its ready low and holds its request and data steady until it is connected.

Top module: `xbarTop`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every tgtSel and initReady bit is low, and every target turn pointer starts at initiator 0.
- R2: Requests raised before a clock edge to distinct idle targets are all granted at that edge, and all of them see tgtSel and initReady high together from the next cycle.
- R3: A target that no initiator requests keeps its tgtSel low, no matter how many initiators contend for other targets.
- R4: An idle target grants, at the next edge, the requester found first when searching upward (with wraparound) from its turn pointer; a pointer on a non-requesting initiator skips to the next requester.
- R5: A grant is held until the owner raises initDone in a cycle in which that target's tgtReady is high; a done flag seen while tgtReady is low does not end it, and other requesters keep initReady low meanwhile.
- R6: When a transaction ends, that target's turn pointer moves to the owner's index plus one, wrapping from the last initiator to 0.
- R7: While connected, tgtWdata of the target carries the owner's initWdata and initRdata/initReady of the owner carry that target's tgtRdata/tgtReady; slices with no connection read zero.
- R8: tgtDone of a granted target forwards its owner's initDone; it is zero on idle targets.
- R9: A released target is idle for exactly one cycle (tgtSel low) before a waiting requester is connected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | NUM_INIT | Request per initiator |
| initTgt | input | NUM_INIT*TGT_W | Wanted target index, initiator i at bits [i*TGT_W +: TGT_W] |
| initWdata | input | NUM_INIT*DATA_W | Write data, initiator i at bits [i*DATA_W +: DATA_W] |
| initDone | input | NUM_INIT | Last cycle of the initiator's transaction |
| initReady | output | NUM_INIT | Connected target is ready |
| initRdata | output | NUM_INIT*DATA_W | Response data from the connected target |
| tgtSel | output | NUM_TGT | Target selected by its owner |
| tgtWdata | output | NUM_TGT*DATA_W | Write data routed from the owner |
| tgtDone | output | NUM_TGT | Owner's done flag routed to the target |
| tgtReady | input | NUM_TGT | Target can complete the current cycle |
| tgtRdata | input | NUM_TGT*DATA_W | Response data from each target |

## Verification
The matrix is tried with every initiator aimed at its own target, which separates true per-target arbitration from a single shared grant, and with all initiators aimed at one target, which exposes the rotation order and the pointer step after each completion. A pattern where the pointer rests on an idle initiator tells a skipping search apart from one that stalls, and a done flag during a not-ready cycle tells a held grant apart from an early release. A single connection to a non-zero target checks that data, ready and done travel on the right lanes and that every other lane reads zero.

// File: rtl/xbarPkg.sv
package xbarPkg;
  parameter int NUM_INIT = 3;
  parameter int NUM_TGT  = 3;
  parameter int DATA_W   = 8;
  localparam int IDX_W = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1;
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  // strobes from the arbiters to the switch matrix
  typedef struct packed {
    logic [NUM_TGT-1:0]            busy;
    logic [NUM_TGT-1:0][IDX_W-1:0] owner;
  } xbarCtl_t;
endpackage

// File: rtl/xbarArbCtl.sv
module xbarArbCtl
  import xbarPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_INIT-1:0]         initReq,
  input  logic [NUM_INIT*TGT_W-1:0]   initTgt,
  input  logic [NUM_INIT-1:0]         initDone,
  input  logic [NUM_TGT-1:0]          tgtReady,
  output xbarCtl_t                    ctl
);
  logic [NUM_TGT-1:0]            busyV;
  logic [NUM_TGT-1:0][IDX_W-1:0] ownerV;

  for (genvar t = 0; t < NUM_TGT; t++) begin : gTgt
    logic [NUM_INIT-1:0] cand;
    logic [IDX_W-1:0]    ptrQ, ownerQ, pick;
    logic                busyQ, found, fin;

    always_comb begin
      for (int i = 0; i < NUM_INIT; i++)
        cand[i] = initReq[i] && (initTgt[i*TGT_W +: TGT_W] == TGT_W'(t));
    end

    // rotating search starting at the turn pointer
    always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int k = 0; k < NUM_INIT; k++) begin
        int s;
        s = int'(ptrQ) + k;
        if (s >= NUM_INIT) s = s - NUM_INIT;
        if (!found && cand[s]) begin
          pick  = IDX_W'(s);
          found = 1'b1;
        end
      end
    end

    assign fin = busyQ && initDone[ownerQ] && tgtReady[t];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ  <= 1'b0;
        ownerQ <= '0;
        ptrQ   <= '0;
      end else if (busyQ) begin
        if (fin) begin
          busyQ <= 1'b0;
          ptrQ  <= (int'(ownerQ) == NUM_INIT-1) ? '0 : ownerQ + 1'b1;
        end
      end else if (found) begin
        busyQ  <= 1'b1;
        ownerQ <= pick;
      end
    end

    assign busyV[t]  = busyQ;
    assign ownerV[t] = ownerQ;
  end

  assign ctl.busy  = busyV;
  assign ctl.owner = ownerV;
endmodule

// File: rtl/xbarSwitch.sv
module xbarSwitch
  import xbarPkg::*;
(
  input  xbarCtl_t                    ctl,
  input  logic [NUM_INIT-1:0]         initReq,
  input  logic [NUM_INIT*DATA_W-1:0]  initWdata,
  input  logic [NUM_INIT-1:0]         initDone,
  output logic [NUM_INIT-1:0]         initReady,
  output logic [NUM_INIT*DATA_W-1:0]  initRdata,
  output logic [NUM_TGT-1:0]          tgtSel,
  output logic [NUM_TGT*DATA_W-1:0]   tgtWdata,
  output logic [NUM_TGT-1:0]          tgtDone,
  input  logic [NUM_TGT-1:0]          tgtReady,
  input  logic [NUM_TGT*DATA_W-1:0]   tgtRdata
);
  // initiator-to-target direction
  always_comb begin
    tgtSel   = '0;
    tgtDone  = '0;
    tgtWdata = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (ctl.busy[t]) begin
        tgtSel[t]                   = initReq[ctl.owner[t]];
        tgtDone[t]                  = initDone[ctl.owner[t]];
        tgtWdata[t*DATA_W +: DATA_W] = initWdata[int'(ctl.owner[t])*DATA_W +: DATA_W];
      end
    end
  end

  // target-to-initiator direction
  always_comb begin
    initReady = '0;
    initRdata = '0;
    for (int i = 0; i < NUM_INIT; i++) begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (ctl.busy[t] && (ctl.owner[t] == IDX_W'(i))) begin
          initReady[i]                  = tgtReady[t];
          initRdata[i*DATA_W +: DATA_W] = tgtRdata[t*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/xbarTop.sv
module xbarTop
  import xbarPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_INIT-1:0]         initReq,
  input  logic [NUM_INIT*TGT_W-1:0]   initTgt,
  input  logic [NUM_INIT*DATA_W-1:0]  initWdata,
  input  logic [NUM_INIT-1:0]         initDone,
  output logic [NUM_INIT-1:0]         initReady,
  output logic [NUM_INIT*DATA_W-1:0]  initRdata,
  output logic [NUM_TGT-1:0]          tgtSel,
  output logic [NUM_TGT*DATA_W-1:0]   tgtWdata,
  output logic [NUM_TGT-1:0]          tgtDone,
  input  logic [NUM_TGT-1:0]          tgtReady,
  input  logic [NUM_TGT*DATA_W-1:0]   tgtRdata
);
  xbarCtl_t ctl;

  xbarArbCtl ctl_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .initTgt(initTgt),
    .initDone(initDone), .tgtReady(tgtReady), .ctl(ctl)
  );

  xbarSwitch sw_i (
    .ctl(ctl), .initReq(initReq), .initWdata(initWdata), .initDone(initDone),
    .initReady(initReady), .initRdata(initRdata), .tgtSel(tgtSel),
    .tgtWdata(tgtWdata), .tgtDone(tgtDone), .tgtReady(tgtReady),
    .tgtRdata(tgtRdata)
  );
endmodule

// File: rtl/xbarChecker.sv
module xbarChecker
  import xbarPkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_INIT-1:0]       initReq,
  input logic [NUM_INIT*TGT_W-1:0] initTgt,
  input logic [NUM_INIT-1:0]       initDone,
  input logic [NUM_INIT-1:0]       initReady,
  input logic [NUM_TGT-1:0]        tgtReady,
  input logic [NUM_TGT-1:0]        tgtSel,
  input xbarCtl_t                  ctl
);
  logic [NUM_INIT-1:0][NUM_TGT-1:0] ownVec;
  always_comb begin
    for (int i = 0; i < NUM_INIT; i++)
      for (int t = 0; t < NUM_TGT; t++)
        ownVec[i][t] = ctl.busy[t] && (ctl.owner[t] == IDX_W'(i));
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : gChkT
    logic [NUM_INIT-1:0] wantQ, want;
    logic fin;
    always_comb begin
      for (int i = 0; i < NUM_INIT; i++)
        want[i] = initReq[i] && (initTgt[i*TGT_W +: TGT_W] == TGT_W'(t));
    end
    assign fin = ctl.busy[t] && initDone[ctl.owner[t]] && tgtReady[t];
    always_ff @(posedge clk) wantQ <= want;

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
      ctl.busy[t] && !fin |=> ctl.busy[t] && $stable(ctl.owner[t])); // R5
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      fin |=> !ctl.busy[t]); // R9
    AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.busy[t] |=> !ctl.busy[t] || wantQ[ctl.owner[t]]); // R4
    AST_SEL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
      tgtSel[t] |-> ctl.busy[t]); // R3
  end

  for (genvar i = 0; i < NUM_INIT; i++) begin : gChkI
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rstN)
      $countones(ownVec[i]) <= 1); // R2
    AST_READY_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
      initReady[i] |-> (|ownVec[i])); // R7
  end
endmodule

bind xbarTop xbarChecker chk_i (
  .clk(clk), .rstN(rstN), .initReq(initReq), .initTgt(initTgt),
  .initDone(initDone), .initReady(initReady), .tgtReady(tgtReady),
  .tgtSel(tgtSel), .ctl(ctl)
);

// File: tb/xbarTop_tb_top.sv
`timescale 1ns/1ps
module xbarTop_tb_top;
  import xbarPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_INIT-1:0]         initReq = '0;
  logic [NUM_INIT*TGT_W-1:0]   initTgt = '0;
  logic [NUM_INIT*DATA_W-1:0]  initWdata;
  logic [NUM_INIT-1:0]         initDone = '0;
  logic [NUM_INIT-1:0]         initReady;
  logic [NUM_INIT*DATA_W-1:0]  initRdata;
  logic [NUM_TGT-1:0]          tgtSel;
  logic [NUM_TGT*DATA_W-1:0]   tgtWdata;
  logic [NUM_TGT-1:0]          tgtDone;
  logic [NUM_TGT-1:0]          tgtReady = '1;
  logic [NUM_TGT*DATA_W-1:0]   tgtRdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // fixed data patterns: initiator i writes 0x10+i, target t answers 0xA0+t
  always_comb begin
    for (int i = 0; i < NUM_INIT; i++) initWdata[i*DATA_W +: DATA_W] = DATA_W'(8'h10 + i);
    for (int t = 0; t < NUM_TGT; t++)  tgtRdata[t*DATA_W +: DATA_W]  = DATA_W'(8'hA0 + t);
  end

  xbarTop dut_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .initTgt(initTgt),
    .initWdata(initWdata), .initDone(initDone), .initReady(initReady),
    .initRdata(initRdata), .tgtSel(tgtSel), .tgtWdata(tgtWdata),
    .tgtDone(tgtDone), .tgtReady(tgtReady), .tgtRdata(tgtRdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {req[3], tgt[6] (i2,i1,i0), done[3], tgtReady[3], expSel[3], expReady[3]}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {3'b000, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b111, 6'b100100, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b111, 6'b100100, 3'b000, 3'b111, 3'b111, 3'b111},
    {3'b111, 6'b100100, 3'b111, 3'b111, 3'b111, 3'b111},
    {3'b000, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b111, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b111, 6'b000000, 3'b000, 3'b111, 3'b001, 3'b010},
    {3'b111, 6'b000000, 3'b010, 3'b111, 3'b001, 3'b010},
    {3'b101, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b101, 6'b000000, 3'b000, 3'b111, 3'b001, 3'b100},
    {3'b101, 6'b000000, 3'b100, 3'b111, 3'b001, 3'b100},
    {3'b101, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b101, 6'b000000, 3'b000, 3'b111, 3'b001, 3'b001},
    {3'b101, 6'b000000, 3'b001, 3'b110, 3'b001, 3'b000},
    {3'b101, 6'b000000, 3'b000, 3'b111, 3'b001, 3'b001},
    {3'b101, 6'b000000, 3'b001, 3'b111, 3'b001, 3'b001},
    {3'b100, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000},
    {3'b100, 6'b000000, 3'b000, 3'b111, 3'b001, 3'b100},
    {3'b100, 6'b000000, 3'b100, 3'b111, 3'b001, 3'b100},
    {3'b000, 6'b000000, 3'b000, 3'b111, 3'b000, 3'b000}
  };

  function automatic string tagOf(int n);
    if (n <= 4)  return "R2";
    if (n <= 7)  return "R6";
    if (n == 8)  return "R9";
    if (n <= 10) return "R6";
    if (n <= 12) return "R4";
    if (n <= 15) return "R5";
    return "R3";
  endfunction

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds everything idle even with requests pending
    @(negedge clk);
    initReq = 3'b111;
    initTgt = 6'b100100;
    nextCycle();
    #0.5;
    check("R1 tgtSel in reset", 32'(tgtSel), 32'h0);
    check("R1 initReady in reset", 32'(initReady), 32'h0);
    @(negedge clk);
    initReq = '0;
    rstN = 1'b1;
    nextCycle();

    for (int n = 0; n < NV; n++) begin
      {initReq, initTgt, initDone, tgtReady} = VEC[n][20:6];
      #0.5;
      check({tagOf(n), " tgtSel"}, 32'(tgtSel), 32'(VEC[n][5:3]));
      check({tagOf(n), " initReady"}, 32'(initReady), 32'(VEC[n][2:0]));
      nextCycle();
    end

    // R7 and R8: initiator 1 to target 2
    initReq = 3'b010;
    initTgt = 6'b001000;
    initDone = '0;
    tgtReady = '1;
    nextCycle();
    #0.5;
    check("R7 tgtSel", 32'(tgtSel), 32'h4);
    check("R7 tgtWdata", 32'(tgtWdata), 32'h110000);
    check("R7 initRdata", 32'(initRdata), 32'h00A200);
    check("R8 tgtDone low", 32'(tgtDone), 32'h0);
    initDone = 3'b010;
    #0.5;
    check("R8 tgtDone forwarded", 32'(tgtDone), 32'h4);
    tgtReady = 3'b011;
    #0.5;
    check("R7 initReady follows tgtReady", 32'(initReady), 32'h0);
    tgtReady = 3'b111;
    nextCycle();
    initReq = '0;
    initDone = '0;
    #0.5;
    check("R7 idle lanes zero", 32'(tgtWdata), 32'h0);
    check("R8 idle tgtDone", 32'(tgtDone), 32'h0);

    // R1: reset in the middle of a transaction clears the grant
    initReq = 3'b001;
    initTgt = 6'b000001;
    nextCycle();
    #0.5;
    check("R1 granted before reset", 32'(tgtSel), 32'h2);
    @(negedge clk);
    rstN = 1'b0;
    nextCycle();
    initReq = 3'b011;
    initTgt = 6'b000000;
    rstN = 1'b1;
    #0.5;
    check("R1 grant cleared", 32'(tgtSel), 32'h0);
    nextCycle();
    #0.5;
    // pointer back at initiator 0 after reset
    check("R1 pointer at zero", 32'(initReady), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule